// File: doc/BRIEF.md
# Spread-Spectrum Triangle Profile Generator

This block produces the fractional input word of a divider modulator in a frequency synthesizer. Once per reference clock it presents a word that moves along a symmetric triangle, so the synthesized clock is frequency-modulated and its spectral energy is spread out. The triangle lies around a programmable mean word. A direction control places the triangle either centered on that mean or entirely below it (down spread). A two-bit ratio code scales a base amplitude by 1, 2, 4 or 8, which gives the 0.4 %, 0.8 %, 1.6 % and 3.2 % peak-to-peak settings when the base amplitude is chosen for the operating point.

The half-ramp length is a parameter (179 cycles by default, so one triangle period is 358 update cycles, about 40 kHz at a 14.318 MHz reference). The per-cycle step is spread exactly with a remainder accumulator, so each ramp covers exactly twice the amplitude with no overshoot. For an extended-range modulator, a shift control raises the mean by 2^BT and lowers the integer divide value by one. This keeps a profile that would cross the unit boundary inside the usable input range. When modulation is disabled the block outputs the shifted mean alone. The controls are meant to be changed only while modulation is disabled.

Top module: `ssc_profile_gen`

## Requirements
- R1: While modEn is low, including during and after reset, fracOut equals meanIn plus 2^BT when meanShift is 1 (meanIn alone when meanShift is 0), and turnPulse is 0.
- R2: intOut always equals intIn minus meanShift.
- R3: The amplitude A equals ampBase shifted left by ratioSel (code 0 gives x1, 1 gives x2, 2 gives x4, 3 gives x8).
- R4: With downSpread = 0 the lower limit is M - A and the upper limit is M + A, where M is the shifted mean of R1.
- R5: With downSpread = 1 the upper limit equals M and the lower limit is M - 2A.
- R6: In the first cycle that modEn is high after being low, fracOut equals the lower limit and the ramp rises.
- R7: In cycle n after enable, with p = n mod 2*HALF, fracOut equals lo + floor(2A*p/HALF) for p < HALF and hi - floor(2A*(p-HALF)/HALF) otherwise. It never leaves [lo, hi].
- R8: turnPulse is 1 exactly in the cycles with p = 0 (valley) and p = HALF (peak), so the triangle period is 2*HALF cycles.
- R9: The sum of fracOut over any full period equals HALF*(lo+hi), so the average is the programmed center.
- R10: Dropping modEn returns fracOut to the mean in the same cycle. Raising it again restarts the ramp at the valley.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate update clock |
| rstN | input | 1 | Active-low synchronous reset |
| modEn | input | 1 | Enables the triangle; low outputs the mean only |
| downSpread | input | 1 | 0 gives center spread, 1 gives down spread |
| ratioSel | input | 2 | Deviation code, amplitude = ampBase << ratioSel |
| ampBase | input | BT | Amplitude for the smallest deviation code |
| meanIn | input | BT+2 | Nominal mean word |
| meanShift | input | 1 | Adds 2^BT to the mean and subtracts 1 from intOut |
| intIn | input | IW | Nominal integer divide value |
| fracOut | output | BT+2 | Word for the divider modulator |
| intOut | output | IW | Integer divide value after the shift adjustment |
| turnPulse | output | 1 | High in the cycle the word sits at a peak or valley |

## Verification
The bench builds the block with BT = 10 and the default HALF = 179. HALF is prime, so nearly every amplitude leaves a non-zero remainder in the step accumulator, and the exact end-of-ramp landing and the period-sum identity are tested under real carry patterns. With these values the full 1 to 3*2^BT - 1 word range can be reached, and so can the 3.2 % center case whose sweep crosses 2^BT, with and without the mean shift. A period is only 358 cycles, so many random settings are each run for two full periods.

// File: rtl/ssc_profile_pkg.sv
package ssc_profile_pkg;
  // Strobes passed from the sequencing control to the ramp datapath
  typedef struct packed {
    logic restart;  // clear ramp offset and remainder on the next edge
    logic turn;     // current word sits at a peak or valley
    logic rising;   // current half ramp goes upward
  } profStrobe_t;
endpackage

// File: rtl/ssc_profile_ctrl.sv
module ssc_profile_ctrl
  import ssc_profile_pkg::*;
#(
  parameter int HALF = 179
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modEn,
  output profStrobe_t strobe
);
  localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] kCnt;
  logic          dirUp;

  always_ff @(posedge clk) begin
    if (!rstN || !modEn) begin
      kCnt  <= '0;
      dirUp <= 1'b1;
    end else if (kCnt == LAST) begin
      kCnt  <= '0;
      dirUp <= ~dirUp;
    end else begin
      kCnt <= kCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.restart = !modEn || (kCnt == LAST);
    strobe.turn    = modEn && (kCnt == '0);
    strobe.rising  = dirUp;
  end
endmodule

// File: rtl/ssc_profile_dp.sv
module ssc_profile_dp
  import ssc_profile_pkg::*;
#(
  parameter int BT   = 10,
  parameter int HALF = 179
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          modEn,
  input  logic          downSpread,
  input  logic [1:0]    ratioSel,
  input  logic [BT-1:0] ampBase,
  input  logic [BT+1:0] meanIn,
  input  logic          meanShift,
  input  profStrobe_t   strobe,
  output logic [BT+1:0] fracOut
);
  localparam int OW = BT + 2;
  localparam int W  = OW + 4;
  localparam int RW = $clog2(HALF) + 2;
  localparam logic [W-1:0]  HALF_W = W'(HALF);
  localparam logic [RW-1:0] HALF_R = RW'(HALF);

  logic [W-1:0]  amp, twoAmp, stepQ, stepRw, meanEff, loLim, hiLim;
  logic [W-1:0]  offs;
  logic [RW-1:0] rem, remSum, stepR;
  logic          carry;

  always_comb begin
    amp     = W'(ampBase) << ratioSel;
    twoAmp  = amp << 1;
    stepQ   = twoAmp / HALF_W;
    stepRw  = twoAmp % HALF_W;
    stepR   = stepRw[RW-1:0];
    meanEff = W'(meanIn) + (meanShift ? (W'(1) << BT) : '0);
    if (downSpread) begin
      hiLim = meanEff;
      loLim = meanEff - twoAmp;
    end else begin
      hiLim = meanEff + amp;
      loLim = meanEff - amp;
    end
    remSum = rem + stepR;
    carry  = (remSum >= HALF_R);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) begin
      offs <= '0;
      rem  <= '0;
    end else if (carry) begin
      offs <= offs + stepQ + W'(1);
      rem  <= remSum - HALF_R;
    end else begin
      offs <= offs + stepQ;
      rem  <= remSum;
    end
  end

  logic [W-1:0] rampWord;
  always_comb begin
    rampWord = strobe.rising ? (loLim + offs) : (hiLim - offs);
    fracOut  = modEn ? rampWord[OW-1:0] : meanEff[OW-1:0];
  end
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_profile_pkg::*;
#(
  parameter int BT   = 10,
  parameter int HALF = 179,
  parameter int IW   = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          modEn,
  input  logic          downSpread,
  input  logic [1:0]    ratioSel,
  input  logic [BT-1:0] ampBase,
  input  logic [BT+1:0] meanIn,
  input  logic          meanShift,
  input  logic [IW-1:0] intIn,
  output logic [BT+1:0] fracOut,
  output logic [IW-1:0] intOut,
  output logic          turnPulse
);
  profStrobe_t strobe;

  ssc_profile_ctrl #(.HALF(HALF)) uCtrl (
    .clk(clk), .rstN(rstN), .modEn(modEn), .strobe(strobe)
  );

  ssc_profile_dp #(.BT(BT), .HALF(HALF)) uDp (
    .clk(clk), .rstN(rstN), .modEn(modEn), .downSpread(downSpread),
    .ratioSel(ratioSel), .ampBase(ampBase), .meanIn(meanIn),
    .meanShift(meanShift), .strobe(strobe), .fracOut(fracOut)
  );

  assign turnPulse = strobe.turn;
  assign intOut    = intIn - IW'(meanShift);
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
  parameter int BT   = 10,
  parameter int HALF = 179,
  parameter int IW   = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          modEn,
  input logic [BT+1:0] meanIn,
  input logic          meanShift,
  input logic [IW-1:0] intIn,
  input logic [BT+1:0] fracOut,
  input logic [IW-1:0] intOut,
  input logic          turnPulse
);
  localparam int SW = $clog2(HALF) + 1;
  logic [SW-1:0] sinceTurn;
  logic          enSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceTurn <= '0;
      enSeen    <= 1'b0;
    end else begin
      enSeen <= modEn;
      if (!modEn || turnPulse) sinceTurn <= '0;
      else                     sinceTurn <= sinceTurn + 1'b1;
    end
  end

  AST_IDLE_MEAN: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |-> (fracOut == (meanIn + ((BT+2)'(meanShift) << BT)))); // R1
  AST_IDLE_NO_TURN: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |-> !turnPulse); // R1
  AST_INT_ADJUST: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> (intOut == intIn - IW'(meanShift))); // R2
  AST_START_VALLEY: assert property (@(posedge clk) disable iff (!rstN)
    (modEn && !enSeen) |-> turnPulse); // R6
  AST_TURN_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (modEn && enSeen) |-> (turnPulse == (sinceTurn == SW'(HALF - 1)))); // R8
endmodule

bind ssc_profile_gen ssc_profile_chk #(.BT(BT), .HALF(HALF), .IW(IW)) uChk (
  .clk(clk), .rstN(rstN), .modEn(modEn), .meanIn(meanIn),
  .meanShift(meanShift), .intIn(intIn), .fracOut(fracOut),
  .intOut(intOut), .turnPulse(turnPulse)
);

// File: tb/sim_ssc_profile_gen.sv
module sim_ssc_profile_gen;
  localparam int BT   = 10;
  localparam int HALF = 179;
  localparam int IW   = 6;
  localparam int TOP  = 3 * (1 << BT) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modEn = 1'b0;
  logic          downSpread = 1'b0;
  logic [1:0]    ratioSel = '0;
  logic [BT-1:0] ampBase = '0;
  logic [BT+1:0] meanIn = '0;
  logic          meanShift = 1'b0;
  logic [IW-1:0] intIn = '0;
  logic [BT+1:0] fracOut;
  logic [IW-1:0] intOut;
  logic          turnPulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ssc_profile_gen #(.BT(BT), .HALF(HALF), .IW(IW)) u0 (
    .clk(clk), .rstN(rstN), .modEn(modEn), .downSpread(downSpread),
    .ratioSel(ratioSel), .ampBase(ampBase), .meanIn(meanIn),
    .meanShift(meanShift), .intIn(intIn), .fracOut(fracOut),
    .intOut(intOut), .turnPulse(turnPulse)
  );

  function automatic int ampOf(int base, int code);
    return base * (1 << code);
  endfunction
  function automatic int meanOf(int m, bit sh);
    return m + (sh ? (1 << BT) : 0);
  endfunction
  function automatic int loOf(int m, int a, bit dn);
    return dn ? m - 2 * a : m - a;
  endfunction
  function automatic int hiOf(int m, int a, bit dn);
    return dn ? m : m + a;
  endfunction
  function automatic int wordAt(int lo, int hi, int a, int n);
    int p = n % (2 * HALF);
    if (p < HALF) return lo + (2 * a * p) / HALF;
    return hi - (2 * a * (p - HALF)) / HALF;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkIdle();
    int m = meanOf(int'(meanIn), meanShift);
    check(int'(fracOut) == m, "R1 idle mean", int'(fracOut), m);
    check(turnPulse == 1'b0, "R1 idle turn", int'(turnPulse), 0);
    check(int'(intOut) == ((int'(intIn) - int'(meanShift)) & ((1 << IW) - 1)),
          "R2 int adjust", int'(intOut), int'(intIn) - int'(meanShift));
  endtask

  // Runs two full periods with the present settings, starting from idle
  task automatic runProfile(bit dn, int code, int base, int mIn, bit sh);
    int a, m, lo, hi;
    longint sum;
    int turns, lastTurn, mism, minV, maxV;
    @(negedge clk);
    modEn = 1'b0; downSpread = dn; ratioSel = 2'(code);
    ampBase = BT'(base); meanIn = (BT+2)'(mIn); meanShift = sh;
    intIn = IW'($urandom_range(2, 60));
    #1 checkIdle();
    a = ampOf(base, code); m = meanOf(mIn, sh);
    lo = loOf(m, a, dn); hi = hiOf(m, a, dn);
    @(negedge clk);
    modEn = 1'b1;
    #1;
    check(int'(fracOut) == lo, "R6 start at valley", int'(fracOut), lo);
    sum = 0; turns = 0; lastTurn = -1; mism = 0; minV = TOP + 1; maxV = -1;
    for (int n = 0; n < 4 * HALF; n++) begin
      int exp = wordAt(lo, hi, a, n);
      bit expT = ((n % HALF) == 0);
      if (n > 0) begin @(negedge clk); #1; end
      if (int'(fracOut) != exp) begin
        if (mism == 0)
          check(1'b0, "R7 ramp word", int'(fracOut), exp);
        mism++;
      end
      if (turnPulse != expT) begin
        check(1'b0, "R8 turn pulse", int'(turnPulse), int'(expT));
      end
      if (int'(fracOut) < minV) minV = int'(fracOut);
      if (int'(fracOut) > maxV) maxV = int'(fracOut);
      if (n < 2 * HALF) sum += longint'(fracOut);
      if (turnPulse) begin
        if (lastTurn >= 0)
          check(n - lastTurn == HALF, "R8 half spacing", n - lastTurn, HALF);
        lastTurn = n; turns++;
      end
    end
    check(mism == 0, "R7 all ramp words", mism, 0);
    check(turns == 4, "R8 turns in two periods", turns, 4);
    check(minV == lo, dn ? "R5 down lower limit" : "R4 center lower limit", minV, lo);
    check(maxV == hi, dn ? "R5 down upper limit" : "R4 center upper limit", maxV, hi);
    check(maxV - minV == 2 * a, "R3 amplitude", maxV - minV, 2 * a);
    check(sum == longint'(HALF) * longint'(lo + hi), "R9 period average",
          int'(sum), HALF * (lo + hi));
    @(negedge clk);
    modEn = 1'b0;
    #1 checkIdle();
    check(int'(fracOut) == m, "R10 disable returns mean", int'(fracOut), m);
  endtask

  initial begin
    int seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    meanIn = 12'd700; meanShift = 1'b1; intIn = 6'd20;
    #1 checkIdle();               // R1 during reset
    @(negedge clk); rstN = 1'b1;
    #1 checkIdle();               // R1 after reset

    // Directed: 3.2 % center sweep crossing 2^BT
    runProfile(1'b0, 3, 43, 975, 1'b0);
    // Same profile with the mean shifted up by 2^BT
    runProfile(1'b0, 3, 43, 975 - 1024 + 1024, 1'b1);
    // Down spread, smallest code
    runProfile(1'b1, 0, 43, 1500, 1'b0);
    // Zero amplitude: flat output, turns still periodic
    runProfile(1'b0, 2, 0, 800, 1'b0);
    // Amplitude below one step per cycle
    runProfile(1'b0, 1, 5, 300, 1'b0);
    // Top of range
    runProfile(1'b0, 3, 60, TOP - 480, 1'b0);

    // R10: mid-ramp drop restarts at the valley
    @(negedge clk); modEn = 1'b1;
    repeat (50) @(negedge clk);
    modEn = 1'b0; #1 checkIdle();
    @(negedge clk); modEn = 1'b1; #1;
    check(int'(fracOut) == loOf(meanOf(int'(meanIn), meanShift),
          ampOf(60, 3), 1'b0), "R10 restart at valley", int'(fracOut),
          loOf(meanOf(int'(meanIn), meanShift), ampOf(60, 3), 1'b0));
    check(turnPulse == 1'b1, "R10 restart turn", int'(turnPulse), 1);
    @(negedge clk); modEn = 1'b0;

    // Random settings kept inside 1 .. 3*2^BT-1
    for (int t = 0; t < 24; t++) begin
      bit dn = 1'($urandom_range(0, 1));
      int code = $urandom_range(0, 3);
      int base = $urandom_range(0, 60);
      int a = ampOf(base, code);
      int m = $urandom_range(2 * a + 1, TOP - 2 * a);
      bit sh = (m >= (1 << BT)) ? 1'($urandom_range(0, 1)) : 1'b0;
      runProfile(dn, code, base, sh ? m - (1 << BT) : m, sh);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule